// File: doc/BRIEF.md
# Video Pixel Output Port Formatter

This block sits at the end of a video pipeline. It takes one processed pixel per stream beat (a luma or green sample, a blue-difference or blue sample, a red-difference or red sample) and drives a 20-lane pixel output bus. The bus layout depends on the selected format. There are narrow interleaved 4:2:2 formats (one component per clock on 8 or 10 lanes), wide 4:2:2 formats (luma and chroma side by side on 16 or 20 lanes), and a 12-lane double-data-rate 4:4:4 RGB format that carries each pixel's 24 bits across both halves of one clock. Horizontal sync, vertical sync and a shared field/data-enable pin go out with the same delay as the data.

Pixels enter over a valid/ready stream. A beat is taken on a rising edge where `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the source must hold the beat's data and its start-of-line flag unchanged. The block lowers `in_ready` for exactly one cycle after each beat taken in a narrow format, because it needs that cycle to send the held luma. It never stalls in the other formats. The output side has no back-pressure. The DDR output cells are modelled by two register phases. A negative-edge register launches the rising-half word, and a positive-edge register launches the falling-half word.

Top module: `vid_pix_fmt`

## Requirements
- R1: While `rst_n` is low, `pix_bus`, `hs_o`, `vs_o` and `fld_de_o` are 0 and `in_ready` is 1.
- R2: Format code 0 (8-bit 4:2:2) turns each beat into two output cycles: first its chroma, then its luma, each as the upper 8 bits of the 10-bit sample on `pix_bus[7:0]`, with `pix_bus[19:8]` at 0. `in_ready` is low in the cycle after each such beat.
- R3: Format code 1 (10-bit 4:2:2) works as in R2, but the full 10-bit component goes on `pix_bus[9:0]` and `pix_bus[19:10]` is 0.
- R4: Format code 2 (16-bit 4:2:2) sends one beat per clock. `pix_bus[15:8]` carries luma bits 9..2, `pix_bus[7:0]` carries chroma bits 9..2, and `pix_bus[19:16]` is 0.
- R5: Format code 3 (20-bit 4:2:2) sends one beat per clock as {luma, chroma} on `pix_bus[19:10]` and `pix_bus[9:0]`. Codes 5, 6 and 7 behave as code 3.
- R6: The chroma component of a beat flagged `in_sol` is Cb. After that, beats alternate Cr, Cb, Cr and so on until the next flagged beat, whatever the number of beats on the previous line.
- R7: Format code 4 (12-bit DDR RGB) uses R, G and B as the upper 8 bits of `in_cr`, `in_y` and `in_cb`. During the high clock phase, B[7:0] is on `pix_bus[7:0]` and G[3:0] is on `pix_bus[11:8]`. During the low phase, R[3:0] is on `pix_bus[3:0]`, G[7:4] is on `pix_bus[7:4]` and R[7:4] is on `pix_bus[11:8]`. `pix_bus[19:12]` is 0 in both phases.
- R8: A beat taken at rising edge N appears in the high phase after rising edge N+1. The SDR bus and the sync pins change only on falling edges, so they are stable across each rising edge. Sync inputs sampled at edge N change the pins at the falling edge that follows edge N.
- R9: With `de_sel` = 1, `fld_de_o` is high exactly in the output cycles that carry pixel data. With `de_sel` = 0, it carries `in_field` with the same delay as `hs_o`.
- R10: A new `fmt_sel` takes effect only on a beat flagged `in_sol`. A change between such beats has no effect on the output layout.
- R11: In a cycle with no pixel data, `pix_bus` is 0.
- R12: Beats are emitted in the order they were taken, with none lost or duplicated, and `in_ready` is never low for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 3 | Output format code, latched at line start |
| de_sel | input | 1 | 1: field pin carries data enable; 0: carries field |
| in_valid | input | 1 | Stream beat valid |
| in_ready | output | 1 | Stream beat accepted when high with in_valid |
| in_sol | input | 1 | Beat is the first active pixel of a line |
| in_y | input | 10 | Luma or green sample |
| in_cb | input | 10 | Blue-difference or blue sample |
| in_cr | input | 10 | Red-difference or red sample |
| in_hs | input | 1 | Horizontal sync in |
| in_vs | input | 1 | Vertical sync in |
| in_field | input | 1 | Field flag in |
| pix_bus | output | 20 | Pixel output lanes |
| hs_o | output | 1 | Horizontal sync out |
| vs_o | output | 1 | Vertical sync out |
| fld_de_o | output | 1 | Field or data-enable out |

## Verification
The bench drives lines with a start-of-line flag in every format and predicts the full lane layout, including the 10-bit samples whose low bits the 8-bit and 16-bit formats must drop. A wrong lane map or a missing zero fill shows up as a data mismatch. Odd-length lines followed at once by a new line catch a chroma phase that fails to restart on Cb. A format change in mid-line catches a design that re-maps lanes inside a line instead of waiting for the next start of line. Bubbles between beats and the narrow-format stall test whether idle cycles read as zero with data enable low, and whether the held luma is lost or sent twice. Each DDR pixel is checked in both clock phases, so swapped or uneven halves fail. A separate probe times the sync pins against the falling edge.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
  localparam int CW     = 10;          // component sample width
  localparam int BUS_W  = 2 * CW;      // output lane count
  localparam int NW     = CW - 2;      // byte-wide component width
  localparam int RGB_W  = 8;           // RGB component width in DDR format
  localparam int HALF   = RGB_W / 2;
  localparam int DDR_W  = RGB_W + HALF; // lanes used per DDR half-word
  localparam int FMT_W  = 3;

  typedef enum logic [FMT_W-1:0] {
    FMT_SDR8  = 3'd0,
    FMT_SDR10 = 3'd1,
    FMT_SDR16 = 3'd2,
    FMT_SDR20 = 3'd3,
    FMT_DDR12 = 3'd4
  } fmt_e;

  // unknown codes fall back to the wide 20-lane layout
  function automatic fmt_e norm_fmt(input logic [FMT_W-1:0] code);
    case (code)
      3'd0:    norm_fmt = FMT_SDR8;
      3'd1:    norm_fmt = FMT_SDR10;
      3'd2:    norm_fmt = FMT_SDR16;
      3'd4:    norm_fmt = FMT_DDR12;
      default: norm_fmt = FMT_SDR20;
    endcase
  endfunction

  function automatic logic is_narrow(input fmt_e f);
    is_narrow = (f == FMT_SDR8) || (f == FMT_SDR10);
  endfunction
endpackage

// File: rtl/vpf_seq.sv
// Stream acceptance, luma hold for interleaved formats, chroma phase
// and the line-boundary format latch.
module vpf_seq
  import vpf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sol,
  input  logic [FMT_W-1:0] fmt_sel,
  input  logic [CW-1:0]    in_y,
  output logic             in_ready,
  output logic             accept,
  output logic             emit,
  output logic             y_phase,
  output logic             chroma_cr,
  output fmt_e             cur_fmt,
  output fmt_e             act_fmt,
  output logic [CW-1:0]    y_out
);
  logic          pend_q;
  logic [CW-1:0] y_hold_q;
  fmt_e          act_q;
  fmt_e          beat_fmt;
  logic          cr_next_q;

  assign in_ready = !pend_q;
  assign accept   = in_valid && in_ready;

  always_comb begin
    if (accept && in_sol) beat_fmt = norm_fmt(fmt_sel);
    else                  beat_fmt = act_q;
  end

  assign chroma_cr = in_sol ? 1'b0 : cr_next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      y_hold_q  <= '0;
      act_q     <= FMT_SDR8;
      cr_next_q <= 1'b0;
    end else if (accept) begin
      act_q     <= beat_fmt;
      cr_next_q <= !chroma_cr;
      pend_q    <= is_narrow(beat_fmt);
      y_hold_q  <= in_y;
    end else if (pend_q) begin
      pend_q <= 1'b0;
    end
  end

  assign emit    = accept || pend_q;
  assign y_phase = pend_q;
  assign cur_fmt = beat_fmt;
  assign act_fmt = act_q;
  assign y_out   = pend_q ? y_hold_q : in_y;
endmodule

// File: rtl/vpf_lane_pack.sv
// Maps components onto output lanes for the current format.
module vpf_lane_pack
  import vpf_pkg::*;
(
  input  fmt_e             fmt,
  input  logic             emit,
  input  logic             y_phase,
  input  logic             chroma_cr,
  input  logic [CW-1:0]    y,
  input  logic [CW-1:0]    cb,
  input  logic [CW-1:0]    cr,
  output logic [BUS_W-1:0] rise_w,
  output logic [BUS_W-1:0] fall_w,
  output logic             is_ddr
);
  logic [CW-1:0]    chroma;
  logic [RGB_W-1:0] r8, g8, b8;

  assign chroma = chroma_cr ? cr : cb;
  assign r8     = cr[CW-1 -: RGB_W];
  assign g8     = y[CW-1 -: RGB_W];
  assign b8     = cb[CW-1 -: RGB_W];

  always_comb begin
    rise_w = '0;
    fall_w = '0;
    is_ddr = 1'b0;
    if (emit) begin
      case (fmt)
        FMT_SDR8: begin
          rise_w[NW-1:0] = y_phase ? y[CW-1 -: NW] : chroma[CW-1 -: NW];
        end
        FMT_SDR10: begin
          rise_w[CW-1:0] = y_phase ? y : chroma;
        end
        FMT_SDR16: begin
          rise_w[2*NW-1:NW] = y[CW-1 -: NW];
          rise_w[NW-1:0]    = chroma[CW-1 -: NW];
        end
        FMT_DDR12: begin
          is_ddr                      = 1'b1;
          rise_w[RGB_W-1:0]           = b8;
          rise_w[DDR_W-1:RGB_W]       = g8[HALF-1:0];
          fall_w[HALF-1:0]            = r8[HALF-1:0];
          fall_w[RGB_W-1:HALF]        = g8[RGB_W-1:HALF];
          fall_w[DDR_W-1:RGB_W]       = r8[RGB_W-1:HALF];
        end
        default: begin
          rise_w = {y, chroma};
        end
      endcase
    end
  end
endmodule

// File: rtl/vpf_out_stage.sv
// Pipeline register plus the two launch phases of the output pins.
module vpf_out_stage
  import vpf_pkg::*;
#(
  parameter bit DDR_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] rise_w,
  input  logic [BUS_W-1:0] fall_w,
  input  logic             is_ddr,
  input  logic             de,
  input  logic             cr_tag,
  input  logic             hs,
  input  logic             vs,
  input  logic             fld,
  output logic [BUS_W-1:0] pix_bus,
  output logic             hs_o,
  output logic             vs_o,
  output logic             fld_o,
  output logic             s_de,
  output logic             s_cr
);
  logic [BUS_W-1:0] s_rise, s_fall, n_rise;
  logic             s_ddr, s_hs, s_vs, s_fld;
  logic [BUS_W-1:0] p_fall;
  logic             p_ddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_rise <= '0;
      s_fall <= '0;
      s_ddr  <= 1'b0;
      s_de   <= 1'b0;
      s_cr   <= 1'b0;
      s_hs   <= 1'b0;
      s_vs   <= 1'b0;
      s_fld  <= 1'b0;
    end else begin
      s_rise <= rise_w;
      s_fall <= fall_w;
      s_ddr  <= is_ddr;
      s_de   <= de;
      s_cr   <= cr_tag;
      s_hs   <= hs;
      s_vs   <= vs;
      s_fld  <= fld;
    end
  end

  // falling-edge launch: SDR data, rising half-word, sync pins
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_rise <= '0;
      hs_o   <= 1'b0;
      vs_o   <= 1'b0;
      fld_o  <= 1'b0;
    end else begin
      n_rise <= s_rise;
      hs_o   <= s_hs;
      vs_o   <= s_vs;
      fld_o  <= s_fld;
    end
  end

  generate
    if (DDR_EN) begin : g_ddr
      // rising-edge launch of the falling half-word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          p_fall <= '0;
          p_ddr  <= 1'b0;
        end else begin
          p_fall <= s_fall;
          p_ddr  <= s_ddr;
        end
      end
    end else begin : g_sdr_only
      assign p_fall = '0;
      assign p_ddr  = 1'b0;
    end
  endgenerate

  assign pix_bus = (!clk && p_ddr) ? p_fall : n_rise;
endmodule

// File: rtl/vid_pix_fmt.sv
module vid_pix_fmt
  import vpf_pkg::*;
#(
  parameter bit DDR_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FMT_W-1:0] fmt_sel,
  input  logic             de_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sol,
  input  logic [CW-1:0]    in_y,
  input  logic [CW-1:0]    in_cb,
  input  logic [CW-1:0]    in_cr,
  input  logic             in_hs,
  input  logic             in_vs,
  input  logic             in_field,
  output logic [BUS_W-1:0] pix_bus,
  output logic             hs_o,
  output logic             vs_o,
  output logic             fld_de_o
);
  logic             accept_w, emit_w, y_phase_w, chroma_cr_w;
  fmt_e             cur_fmt_w, act_fmt_w;
  logic [CW-1:0]    y_w;
  logic [BUS_W-1:0] rise_w, fall_w;
  logic             is_ddr_w, s_de_w, s_cr_w, narrow_w;

  vpf_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
    .fmt_sel(fmt_sel), .in_y(in_y), .in_ready(in_ready),
    .accept(accept_w), .emit(emit_w), .y_phase(y_phase_w),
    .chroma_cr(chroma_cr_w), .cur_fmt(cur_fmt_w), .act_fmt(act_fmt_w),
    .y_out(y_w)
  );

  vpf_lane_pack u_pack (
    .fmt(cur_fmt_w), .emit(emit_w), .y_phase(y_phase_w),
    .chroma_cr(chroma_cr_w), .y(y_w), .cb(in_cb), .cr(in_cr),
    .rise_w(rise_w), .fall_w(fall_w), .is_ddr(is_ddr_w)
  );

  assign narrow_w = is_narrow(cur_fmt_w);

  vpf_out_stage #(.DDR_EN(DDR_EN)) u_out (
    .clk(clk), .rst_n(rst_n), .rise_w(rise_w), .fall_w(fall_w),
    .is_ddr(is_ddr_w), .de(emit_w),
    .cr_tag(emit_w && !y_phase_w && chroma_cr_w),
    .hs(in_hs), .vs(in_vs), .fld(de_sel ? emit_w : in_field),
    .pix_bus(pix_bus), .hs_o(hs_o), .vs_o(vs_o), .fld_o(fld_de_o),
    .s_de(s_de_w), .s_cr(s_cr_w)
  );
endmodule

// File: rtl/vpf_chk.sv
module vpf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_sol,
  input logic       accept,
  input logic       narrow,
  input logic [2:0] act_fmt,
  input logic       s_de,
  input logic       s_cr
);
  // R2/R3: a narrow-format beat is followed by the luma cycle stall
  p_y_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && narrow) |=> !in_ready);

  // R12: the stall never lasts two cycles
  p_single_pause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  // R10: active format moves only on a start-of-line beat
  p_fmt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && in_sol) |=> $stable(act_fmt));

  // R9: no beat taken and nothing pending gives no data enable
  p_idle_no_de_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> !s_de);

  // R6: line start carries Cb
  p_line_cb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_sol) |=> !s_cr);
endmodule

bind vid_pix_fmt vpf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sol(in_sol), .accept(accept_w), .narrow(narrow_w),
  .act_fmt(act_fmt_w), .s_de(s_de_w), .s_cr(s_cr_w)
);

// File: tb/vid_pix_fmt_tb.sv
`timescale 1ns/1ps
module vid_pix_fmt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt_sel = 3'd0;
  logic        de_sel = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sol = 1'b0;
  logic [9:0]  in_y = '0, in_cb = '0, in_cr = '0;
  logic        in_hs = 1'b0, in_vs = 1'b0, in_field = 1'b0;
  logic [19:0] pix_bus;
  logic        hs_o, vs_o, fld_de_o;

  always #2 clk = ~clk;

  vid_pix_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .de_sel(de_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr), .in_hs(in_hs),
    .in_vs(in_vs), .in_field(in_field), .pix_bus(pix_bus),
    .hs_o(hs_o), .vs_o(vs_o), .fld_de_o(fld_de_o)
  );

  typedef struct packed {
    logic [19:0] rw;
    logic [19:0] fw;
    logic        ddr;
    logic [2:0]  fmt;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   failures = 0;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;
  logic [2:0] tb_fmt = 3'd0;
  bit   tb_cr = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [19:0] act,
                     input logic [19:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string fmt_req(input logic [2:0] f);
    case (f)
      3'd0: fmt_req = "R2";
      3'd1: fmt_req = "R3";
      3'd2: fmt_req = "R4";
      3'd4: fmt_req = "R7";
      default: fmt_req = "R5";
    endcase
  endfunction

  // expected model: R10 latch at line start, R6 chroma order, lane maps
  task automatic predict(input logic [9:0] y, cb, cr, input bit sol);
    logic [9:0] ch;
    exp_t e;
    if (sol) begin
      tb_fmt = (fmt_sel > 3'd4) ? 3'd3 : fmt_sel;
      tb_cr  = 1'b0;
    end
    ch = tb_cr ? cr : cb;
    tb_cr = !tb_cr;
    e = '0;
    e.fmt = tb_fmt;
    case (tb_fmt)
      3'd0: begin
        e.rw = {12'd0, ch[9:2]}; q.push_back(e);
        e.rw = {12'd0, y[9:2]};  q.push_back(e);
      end
      3'd1: begin
        e.rw = {10'd0, ch}; q.push_back(e);
        e.rw = {10'd0, y};  q.push_back(e);
      end
      3'd2: begin
        e.rw = {4'd0, y[9:2], ch[9:2]}; q.push_back(e);
      end
      3'd4: begin
        e.ddr = 1'b1;
        e.rw = {8'd0, y[5:2], cb[9:2]};
        e.fw = {8'd0, cr[9:6], y[9:6], cr[5:2]};
        q.push_back(e);
      end
      default: begin
        e.rw = {y, ch}; q.push_back(e);
      end
    endcase
  endtask

  task automatic send(input logic [9:0] y, cb, cr, input bit sol);
    @(negedge clk);
    in_valid = 1'b1; in_sol = sol; in_y = y; in_cb = cb; in_cr = cr;
    while (!in_ready) @(negedge clk);
    predict(y, cb, cr, sol);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_sol = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic send_line(input int n, input int seed);
    for (int i = 0; i < n; i++)
      send(10'(seed + i * 73), 10'(seed * 3 + i * 151 + 7), 10'(seed * 5 + i * 97 + 3),
           i == 0);
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (mon_en) begin
        if (fld_de_o) begin
          if (q.size() == 0) begin
            chk(1'b0, "R9 unexpected data enable", 20'(fld_de_o), 20'd0);
          end else begin
            e = q.pop_front();
            chk(pix_bus == e.rw, fmt_req(e.fmt), pix_bus, e.rw);
            if (e.ddr) begin
              #2;
              chk(pix_bus == e.fw, "R7 low phase", pix_bus, e.fw);
            end
          end
        end else begin
          chk(pix_bus == 20'd0, "R11 idle bus", pix_bus, 20'd0);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(pix_bus == 20'd0, "R1 bus", pix_bus, 20'd0);
    chk({hs_o, vs_o, fld_de_o} == 3'd0, "R1 sync", 20'({hs_o, vs_o, fld_de_o}), 20'd0);
    chk(in_ready == 1'b1, "R1 ready", 20'(in_ready), 20'd1);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    mon_en = 1'b1;

    // R3 / R2 / R4 / R5 / R7 each format, one line each
    for (int f = 0; f < 5; f++) begin
      fmt_sel = 3'(f);
      send_line(6, 40 + f * 11);
      idle(3);
    end

    // R2: stall right after a narrow beat
    fmt_sel = 3'd0;
    send(10'h3FF, 10'h155, 10'h2AA, 1'b1);
    #1;
    chk(in_ready == 1'b0, "R2 stall", 20'(in_ready), 20'd0);
    idle(3);

    // R6: odd-length lines back to back restart on Cb
    fmt_sel = 3'd3;
    send_line(3, 200);
    send_line(3, 300);
    fmt_sel = 3'd1;
    send_line(5, 17);
    send_line(2, 99);
    idle(4);

    // R10: change format mid-line, no effect until next line start
    fmt_sel = 3'd3;
    send(10'h101, 10'h202, 10'h303, 1'b1);
    send(10'h111, 10'h222, 10'h333, 1'b0);
    fmt_sel = 3'd0;
    send(10'h1C3, 10'h0F1, 10'h37D, 1'b0);
    send(10'h2B7, 10'h0A5, 10'h3C3, 1'b0);
    send(10'h0FF, 10'h3FE, 10'h1E1, 1'b1);
    send(10'h2E5, 10'h16B, 10'h35A, 1'b0);
    idle(3);

    // R5: reserved code behaves as 20-bit
    fmt_sel = 3'd6;
    send_line(4, 511);
    idle(3);

    // R11/R12: bubbles between beats in DDR and 16-bit
    fmt_sel = 3'd4;
    send(10'h3C1, 10'h0AA, 10'h255, 1'b1);
    idle(2);
    send(10'h123, 10'h3F0, 10'h00F, 1'b0);
    idle(1);
    send(10'h2D4, 10'h1B9, 10'h36C, 1'b0);
    fmt_sel = 3'd2;
    send(10'h3AB, 10'h1CD, 10'h2EF, 1'b1);
    idle(2);
    send(10'h0A3, 10'h3C5, 10'h151, 1'b0);
    idle(5);

    // R8/R9: sync timing and field pass-through
    mon_en = 1'b0;
    @(negedge clk); de_sel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); in_hs = 1'b1; in_vs = 1'b1; in_field = 1'b1;
    @(posedge clk); #1;
    chk(hs_o == 1'b0, "R8 hs before fall", 20'(hs_o), 20'd0);
    #2;
    chk(hs_o == 1'b1, "R8 hs at fall", 20'(hs_o), 20'd1);
    chk(vs_o == 1'b1, "R8 vs at fall", 20'(vs_o), 20'd1);
    chk(fld_de_o == 1'b1, "R9 field pass", 20'(fld_de_o), 20'd1);
    @(negedge clk); in_hs = 1'b0; in_vs = 1'b0; in_field = 1'b0;
    @(posedge clk); #3;
    chk(fld_de_o == 1'b0, "R9 field low", 20'(fld_de_o), 20'd0);
    chk(hs_o == 1'b0, "R8 hs low", 20'(hs_o), 20'd0);
    @(negedge clk); de_sel = 1'b1;
    repeat (4) @(posedge clk);
    mon_en = 1'b1;
    fmt_sel = 3'd1;
    send_line(4, 77);
    idle(6);

    chk(q.size() == 0, "R12 all beats seen", 20'(q.size()), 20'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule